// File: doc/BRIEF.md
# Receive-Only I2C Write Decoder for a Multichannel DAC

This block is a target-side I2C receiver that runs entirely on the system clock. It samples the bus clock and data lines through synchronising flops, finds start, repeated-start and stop conditions, checks a 7-bit target address and acknowledges every byte it accepts. Accepted bytes are turned into write strobes for a bank of DAC channel registers. Each strobe carries a channel number, a 2-bit register selector and a 14-bit data word.

After one address byte, the controller may send any number of pointer-plus-data groups, and each group updates the channel named by its pointer. A pointer of 0xFF starts a burst instead. In a burst, each pair of data bytes goes to the next channel, counting up from channel 0. After channel 31 the block goes back to expecting a pointer. A stop ends any transfer. A repeated start goes back to address checking.

The host keeps the register storage. It connects `sda_pull_o` to an open-drain pull-down on the data line.

Top module: `i2c_dac_wr_slave`

## Requirements
- R1: While reset is asserted and after it is released, `wr_valid_o` and `sda_pull_o` are 0 and `wr_chan_o`, `wr_reg_o` and `wr_data_o` are all zero.
- R2: An address byte is accepted only when bits 7..3 are 10101, bits 2..1 equal `addr_pin_i`, and bit 0 (the read/write flag) is 0. Any other address byte gets no acknowledge. After a refused address, no further byte is acknowledged and no write is issued until the next start.
- R3: For every accepted byte, `sda_pull_o` rises after the falling bus clock that ends the eighth bit and falls after the falling bus clock that ends the ninth bit. At no other time is it asserted.
- R4: The sequence address, pointer, high data byte, low data byte produces exactly one write to channel = pointer bits 4..0.
- R5: The high data byte carries the register select in bits 7..6 and data bits 13..8 in bits 5..0. The low data byte carries data bits 7..0.
- R6: If no stop follows a data pair, the next byte is a new pointer. Further pointer-plus-data groups each issue one write, and no new address byte is needed.
- R7: A pointer of 0xFF starts a burst. The data pairs that follow write channels 0, 1, 2, ... 31 in order. The byte after the pair for channel 31 is treated as a pointer.
- R8: A stop at any point ends the transfer. A data pair that is not complete is dropped without a write, and the next transfer must start with an address byte.
- R9: A start or repeated start at any point drops any pair that is not complete, and the next byte is checked as an address.
- R10: `wr_valid_o` is a one-cycle pulse for each completed data pair. `wr_chan_o`, `wr_reg_o` and `wr_data_o` change only in a cycle where the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pin_i | input | 2 | Strap value for the two low address bits |
| sda_pull_o | output | 1 | Pull the data line low (acknowledge) |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_chan_o | output | 5 | Channel being written |
| wr_reg_o | output | 2 | Register select for the write |
| wr_data_o | output | 14 | Data word for the write |

## Verification
The bound assertions check, on every cycle, several timing rules:
- the acknowledge pull-down starts only on a detected falling bus clock, and ends only on a falling bus clock or a bus condition;
- a stop always returns the frame decoder to idle, and a start always leaves it out of idle;
- every strobe follows a completed byte and lasts one cycle;
- the write fields stay stable between strobes.

Only the bench scenarios can show which bytes are acknowledged and which writes appear, in which order and with which contents. These scenarios cover refused addresses, single and repeated pointer groups, a full 32-channel burst with the return to pointer mode, truncation by stop and by repeated start, and random traffic.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;
    localparam int unsigned CH_W    = 5;
    localparam int unsigned REG_W   = 2;
    localparam int unsigned DATA_W  = 14;
    localparam int unsigned HI_W    = DATA_W - 8;
    localparam logic [4:0]  ADDR_FIXED = 5'b10101;
    localparam logic [7:0]  BURST_PTR  = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DHI,
        ST_DLO,
        ST_BHI,
        ST_BLO
    } frame_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [1:0] scl_ff;
        logic [1:0] sda_ff;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.scl_ff = {s_q.scl_ff[0], scl_i};
        s_d.sda_ff = {s_q.sda_ff[0], sda_i};
        s_d.scl_p  = s_q.scl_ff[1];
        s_d.sda_p  = s_q.sda_ff[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign sda_o      = s_q.sda_ff[1];
    assign scl_rise_o = s_q.scl_ff[1] & ~s_q.scl_p;
    assign scl_fall_o = ~s_q.scl_ff[1] & s_q.scl_p;
    assign start_o    = s_q.scl_ff[1] & s_q.scl_p & s_q.sda_p & ~s_q.sda_ff[1];
    assign stop_o     = s_q.scl_ff[1] & s_q.scl_p & ~s_q.sda_p & s_q.sda_ff[1];
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       sda_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       ack_ok_i,
    output logic       done_o,
    output logic [7:0] byte_o,
    output logic       pull_o
);
    typedef struct packed {
        logic       active;
        logic [2:0] cnt;
        logic [7:0] shift;
        logic       wait_ack;
        logic       pull;
        logic       done;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (start_i) begin
            r_d.active   = 1'b1;
            r_d.cnt      = '0;
            r_d.wait_ack = 1'b0;
            r_d.pull     = 1'b0;
        end else if (stop_i) begin
            r_d.active   = 1'b0;
            r_d.cnt      = '0;
            r_d.wait_ack = 1'b0;
            r_d.pull     = 1'b0;
        end else if (r_q.active) begin
            if (scl_rise_i && !r_q.wait_ack && !r_q.pull) begin
                r_d.shift = {r_q.shift[6:0], sda_i};
                r_d.cnt   = r_q.cnt + 3'd1;
                if (r_q.cnt == 3'd7) begin
                    r_d.wait_ack = 1'b1;
                    r_d.done     = 1'b1;
                end
            end else if (scl_fall_i && r_q.wait_ack) begin
                r_d.wait_ack = 1'b0;
                if (ack_ok_i) r_d.pull   = 1'b1;
                else          r_d.active = 1'b0;
            end else if (scl_fall_i && r_q.pull) begin
                r_d.pull = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign byte_o = r_q.shift;
    assign pull_o = r_q.pull;
endmodule

// File: rtl/i2c_dac_wr_slave.sv
module i2c_dac_wr_slave
    import i2c_dac_pkg::*;
#(
    parameter int unsigned N_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_pin_i,
    output logic              sda_pull_o,
    output logic              wr_valid_o,
    output logic [CH_W-1:0]   wr_chan_o,
    output logic [REG_W-1:0]  wr_reg_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

    logic       scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic       fsm_idle;

    typedef struct packed {
        frame_st_e          st;
        logic [CH_W-1:0]    chan;
        logic [REG_W-1:0]   rsel;
        logic [HI_W-1:0]    hi;
        logic               accept;
        logic               wv;
        logic [CH_W-1:0]    o_chan;
        logic [REG_W-1:0]   o_reg;
        logic [DATA_W-1:0]  o_data;
    } fr_t;

    fr_t f_d, f_q;

    i2c_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_o      (sda_s),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_byte_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_i      (sda_s),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .ack_ok_i   (f_q.accept),
        .done_o     (byte_done),
        .byte_o     (rx_byte),
        .pull_o     (sda_pull_o)
    );

    always_comb begin
        f_d    = f_q;
        f_d.wv = 1'b0;
        if (start_det) begin
            f_d.st     = ST_ADDR;
            f_d.accept = 1'b0;
        end else if (stop_det) begin
            f_d.st     = ST_IDLE;
            f_d.accept = 1'b0;
        end else if (byte_done) begin
            f_d.accept = 1'b1;
            unique case (f_q.st)
                ST_ADDR: begin
                    if (rx_byte == {ADDR_FIXED, addr_pin_i, 1'b0}) begin
                        f_d.st = ST_PTR;
                    end else begin
                        f_d.st     = ST_IDLE;
                        f_d.accept = 1'b0;
                    end
                end
                ST_PTR: begin
                    if (rx_byte == BURST_PTR) begin
                        f_d.chan = '0;
                        f_d.st   = ST_BHI;
                    end else begin
                        f_d.chan = rx_byte[CH_W-1:0];
                        f_d.st   = ST_DHI;
                    end
                end
                ST_DHI, ST_BHI: begin
                    f_d.rsel = rx_byte[7:6];
                    f_d.hi   = rx_byte[HI_W-1:0];
                    f_d.st   = (f_q.st == ST_DHI) ? ST_DLO : ST_BLO;
                end
                ST_DLO, ST_BLO: begin
                    f_d.wv     = 1'b1;
                    f_d.o_chan = f_q.chan;
                    f_d.o_reg  = f_q.rsel;
                    f_d.o_data = {f_q.hi, rx_byte};
                    if (f_q.st == ST_DLO || f_q.chan == LAST_CH) begin
                        f_d.st = ST_PTR;
                    end else begin
                        f_d.chan = f_q.chan + 1'b1;
                        f_d.st   = ST_BHI;
                    end
                end
                default: f_d.accept = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign fsm_idle   = (f_q.st == ST_IDLE);
    assign wr_valid_o = f_q.wv;
    assign wr_chan_o  = f_q.o_chan;
    assign wr_reg_o   = f_q.o_reg;
    assign wr_data_o  = f_q.o_data;
endmodule

// File: rtl/i2c_dac_wr_chk.sv
module i2c_dac_wr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det,
    input logic        byte_done,
    input logic        fsm_idle,
    input logic        sda_pull_o,
    input logic        wr_valid_o,
    input logic [13:0] wr_data_o
);
    // R3
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    // R3
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> $past(scl_fall || start_det || stop_det));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> fsm_idle);

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !fsm_idle);

    // R10
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R4
    after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> $past(byte_done));

    // R10
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_o |-> $stable(wr_data_o));
endmodule

bind i2c_dac_wr_slave i2c_dac_wr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .byte_done  (byte_done),
    .fsm_idle   (fsm_idle),
    .sda_pull_o (sda_pull_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o)
);

// File: tb/tb_i2c_dac_wr_slave.sv
module tb_i2c_dac_wr_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  pins = 2'b10;
    logic        sda_pull;
    logic        wr_valid;
    logic [4:0]  wr_chan;
    logic [1:0]  wr_reg;
    logic [13:0] wr_data;
    logic        sda_bus;

    int total = 0;
    int bad = 0;
    int n_exp = 0;
    int n_got = 0;
    logic [20:0] exp_q [0:1023];
    logic prev_valid = 1'b0;
    logic finished = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;
    always #5 clk = ~clk;

    i2c_dac_wr_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_pin_i(pins), .sda_pull_o(sda_pull), .wr_valid_o(wr_valid),
        .wr_chan_o(wr_chan), .wr_reg_o(wr_reg), .wr_data_o(wr_data)
    );

    function automatic logic [7:0] hi_byte(input logic [1:0] r, input logic [13:0] d);
        return {r, d[13:8]};
    endfunction

    function automatic logic [7:0] my_addr(input logic rw);
        return {5'b10101, pins, rw};
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // write monitor: R4 R5 R6 R7 R10
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (wr_valid && prev_valid)
                check(0, "R10 strobe longer than one cycle", 2, 1);
            if (wr_valid) begin
                if (n_got >= n_exp)
                    check(0, "R8 unexpected write", {wr_chan, wr_reg, wr_data}, 0);
                else
                    check({wr_chan, wr_reg, wr_data} == exp_q[n_got], "R5 write fields",
                          {wr_chan, wr_reg, wr_data}, exp_q[n_got]);
                n_got++;
            end
        end
        prev_valid = wr_valid;
    end

    task automatic do_start();
        sda_m = 1'b1; wt(8); scl_m = 1'b1; wt(8);
        sda_m = 1'b0; wt(16); scl_m = 1'b0;
    endtask

    task automatic do_stop();
        wt(8); sda_m = 1'b0; wt(8); scl_m = 1'b1; wt(8);
        sda_m = 1'b1; wt(24);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            wt(8); sda_m = b[i]; wt(8); scl_m = 1'b1; wt(16); scl_m = 1'b0;
        end
        wt(8); sda_m = 1'b1; wt(8); scl_m = 1'b1; wt(8);
        check(sda_pull == exp_ack, req, sda_pull, exp_ack);
        wt(8); scl_m = 1'b0;
    endtask

    task automatic send_pair(input logic [4:0] ch, input logic [1:0] r, input logic [13:0] d,
                             input bit record);
        send_byte(hi_byte(r, d), 1'b1, "R3 ack on high data byte");
        if (record) begin
            exp_q[n_exp] = {ch, r, d};
            n_exp++;
        end
        send_byte(d[7:0], 1'b1, "R3 ack on low data byte");
    endtask

    task automatic drain_check(input string req);
        wt(40);
        check(n_got == n_exp, req, n_got, n_exp);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] ch;
        logic [13:0] d;
        logic [1:0] r;
        void'($urandom(32'h0000_5eed));
        wt(5);
        // R1 during reset
        check(!sda_pull && !wr_valid && wr_data == 0 && wr_chan == 0 && wr_reg == 0,
              "R1 outputs in reset", {sda_pull, wr_valid, wr_data}, 0);
        rst_n = 1'b1;
        wt(20);
        check(!sda_pull && !wr_valid && wr_data == 0 && wr_chan == 0 && wr_reg == 0,
              "R1 outputs after reset", {sda_pull, wr_valid, wr_data}, 0);

        // R2 wrong address bits, then no ack on following bytes
        do_start();
        send_byte({5'b10101, ~pins, 1'b0}, 1'b0, "R2 wrong address nack");
        send_byte(8'h03, 1'b0, "R2 no ack after refusal");
        send_byte(8'h12, 1'b0, "R2 no ack after refusal");
        send_byte(8'h34, 1'b0, "R2 no ack after refusal");
        do_stop();
        drain_check("R2 no write after refusal");

        // R2 read flag refused
        do_start();
        send_byte(my_addr(1'b1), 1'b0, "R2 read flag nack");
        do_stop();
        // R2 other fixed bits refused
        do_start();
        send_byte({5'b10100, pins, 1'b0}, 1'b0, "R2 fixed bits mismatch nack");
        do_stop();

        // R4 single format, pointer upper bits ignored
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R2 address ack");
        send_byte(8'h25, 1'b1, "R3 pointer ack");
        send_pair(5'd5, 2'b11, 14'h2A5C, 1'b1);
        do_stop();
        drain_check("R4 single write");

        // R6 repeated pointer groups
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R2 address ack");
        for (int g = 0; g < 4; g++) begin
            ch = 5'($urandom); r = 2'($urandom); d = 14'($urandom);
            send_byte({3'b000, ch}, 1'b1, "R6 pointer ack");
            send_pair(ch, r, d, 1'b1);
        end
        do_stop();
        drain_check("R6 repeated groups");

        // R7 full burst then fallback to pointer mode
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R2 address ack");
        send_byte(8'hFF, 1'b1, "R7 burst pointer ack");
        for (int c = 0; c < 32; c++) begin
            r = 2'($urandom); d = 14'($urandom);
            send_pair(5'(c), r, d, 1'b1);
        end
        send_byte(8'h09, 1'b1, "R7 pointer after burst");
        send_pair(5'd9, 2'b01, 14'h1234, 1'b1);
        do_stop();
        drain_check("R7 burst and fallback");

        // R8 stop inside a pair
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R2 address ack");
        send_byte(8'h07, 1'b1, "R3 pointer ack");
        send_byte(8'h55, 1'b1, "R3 high byte ack");
        do_stop();
        drain_check("R8 truncated pair dropped");
        // R8 next transfer needs an address: a pointer-like first byte is refused
        do_start();
        send_byte(8'h07, 1'b0, "R8 first byte treated as address");
        do_stop();

        // R8 stop inside a burst, next transfer starts fresh
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R2 address ack");
        send_byte(8'hFF, 1'b1, "R7 burst pointer ack");
        send_pair(5'd0, 2'b10, 14'h0001, 1'b1);
        send_pair(5'd1, 2'b00, 14'h3FFF, 1'b1);
        do_stop();
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R2 address ack");
        send_byte(8'h1F, 1'b1, "R8 pointer after stopped burst");
        send_pair(5'd31, 2'b01, 14'h0ABC, 1'b1);
        do_stop();
        drain_check("R8 burst ended by stop");

        // R9 repeated start drops pending pair
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R2 address ack");
        send_byte(8'h0C, 1'b1, "R3 pointer ack");
        send_byte(8'hC1, 1'b1, "R3 high byte ack");
        do_start();
        send_byte(my_addr(1'b0), 1'b1, "R9 address after repeated start");
        send_byte(8'h0D, 1'b1, "R3 pointer ack");
        send_pair(5'd13, 2'b10, 14'h1357, 1'b1);
        do_stop();
        drain_check("R9 repeated start");

        // random traffic
        for (int t = 0; t < 12; t++) begin
            do_start();
            if ($urandom_range(0, 5) == 0) begin
                send_byte(my_addr(1'b1), 1'b0, "R2 random read refused");
            end else begin
                send_byte(my_addr(1'b0), 1'b1, "R2 random address ack");
                for (int g = 0; g < int'($urandom_range(1, 3)); g++) begin
                    ch = 5'($urandom); r = 2'($urandom); d = 14'($urandom);
                    send_byte({3'b000, ch}, 1'b1, "R6 random pointer ack");
                    send_pair(ch, r, d, 1'b1);
                end
            end
            do_stop();
        end
        drain_check("R10 write count");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule